// File: doc/BRIEF.md
# BCD Real-Time Clock with Masked Alarm

This block keeps time of day and a calendar in binary-coded decimal. It holds seconds, minutes, hours, day of week, date, month and a two-digit year. A one-cycle `tick_1hz` pulse advances the count by one second. Counting happens only while `run_en` is high. Hours run in either 24-hour or 12-hour form, chosen by a bit in the hour byte. February gets a 29th day in leap years.

Software reaches the block through a byte-wide register port. A write takes effect in the cycle after `wr_en` is sampled. A read first pulses `rd_cmd`, which copies all seven time bytes into a snapshot. Reads of the time addresses then return that frozen copy, so a multi-byte read is coherent even if the clock ticks partway through. Reads of the alarm bytes return their live contents.

An alarm comparator is evaluated once per second, just after the increment. Bit 7 of each alarm byte is a mask bit, and together the mask bits choose how often the alarm fires: every second, minute, hour, day, week or month. A select bit in the fourth alarm byte picks a weekly (day-of-week) or monthly (date) match. A hit produces a single-cycle `alarm_flag` pulse, but only when both `run_en` and `alarm_en` are high.

Top module: `bcd_rtc`

## Requirements
- R1: After reset every time byte (addresses 0 to 6) and every alarm byte (addresses 8 to 11) reads 00h, and `alarm_flag` is low.
- R2: A `tick_1hz` pulse while `run_en`=1 adds one second. Seconds (address 0) and minutes (address 1) count in BCD from 00 to 59, and the wrap to 00 carries into the next field. With `run_en`=0 a tick changes nothing.
- R3: With hour bit 6 clear (24-hour mode), bits 5:4 of the hour byte (address 2) hold the tens digit. The hour runs 00 to 23, and the wrap from 23 to 00 advances the day.
- R4: With hour bit 6 set (12-hour mode), bits 4:0 hold the hour and bit 5 is PM (1) or AM (0). The hour runs 12, 01 … 11. The step from 11 to 12 toggles bit 5. Day of week and date advance only on the step from 11 PM to 12 AM.
- R5: Day of week (address 3) counts 1 to 7, and 7 wraps to 1 on a day advance.
- R6: Date (address 4) wraps to 01 after the last day of the month (address 5) and advances the month. February has 29 days when the year (address 6) is 00 or a multiple of 4, and 28 days otherwise. Months 04, 06, 09 and 11 have 30 days, and all others have 31. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: Written bytes are masked so that bits defined as always zero stay zero. These are bit 7 of seconds, minutes and hours; bits 7:3 of day of week; bits 7:6 of date; and bits 7:5 of month.
- R8: A `rd_cmd` pulse copies the time bytes into a snapshot. Later reads of addresses 0 to 6 return that snapshot until the next `rd_cmd`, even if the clock advances in between. Alarm bytes at addresses 8 to 11 read live.
- R9: The alarm byte layout and repeat rates are as follows.
  - Alarm bytes 8, 9 and 10 compare bits 6:0 with seconds, minutes and hours.
  - Bit 7 of bytes 8, 9, 10 and 11 is a mask bit. A set bit in byte 8 fires every second.
  - Otherwise, the first set mask bit decides the rate. Byte 9 fires on a seconds match, byte 10 on seconds and minutes, and byte 11 on seconds, minutes and hours.
  - With all four mask bits clear, seconds, minutes, hours and the day field must all match.
- R10: Bits 5:0 of alarm byte 11 are compared with day of week when its bit 6 is 1, and with date when bit 6 is 0.
- R11: `alarm_flag` is a one-cycle pulse two clock cycles after the tick that caused the match. It is issued only when `run_en` and `alarm_en` are both high in the evaluation cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all time and alarm bytes |
| tick_1hz | input | 1 | One-cycle pulse per second |
| run_en | input | 1 | Counting and alarm evaluation allowed |
| alarm_en | input | 1 | Allows the alarm flag to be raised |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| rd_cmd | input | 1 | Captures the time bytes into the read snapshot |
| addr | input | 4 | Byte address (0-6 time, 8-11 alarm) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (snapshot for time bytes) |
| alarm_flag | output | 1 | One-cycle alarm pulse |

## Verification
A wrong carry or digit limit stays hidden until the affected field wraps. It then shows at the ports as a wrong byte in the next snapshot read, one tick after the boundary. For this reason the bench places each field one second before its limit and reads every field back. A mis-wired mask or select bit shows as an `alarm_flag` pulse that is missing or extra, exactly two cycles after a tick, so the flag is checked after every tick.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          run_en,
  input  logic          alarm_en,
  input  logic          wr_en,
  input  logic          rd_cmd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          alarm_flag
);
  localparam logic [7:0] M_SEC = 8'h7F, M_MIN = 8'h7F, M_HR = 8'h7F;
  localparam logic [7:0] M_DOW = 8'h07, M_DAT = 8'h3F, M_MON = 8'h1F;

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] sec_q, min_q, hr_q, dow_q, dat_q, mon_q, yr_q;
  logic [7:0] a_sec, a_min, a_hr, a_day;
  logic [7:0] snap [0:6];
  logic       tick_d;

  wire step = tick_1hz & run_en;
  function automatic logic hit_wr(input logic [AW-1:0] a, input int k);
    return a == AW'(k);
  endfunction

  wire sec_wrap = sec_q == 8'h59;
  wire min_wrap = min_q == 8'h59;
  wire h12      = hr_q[6];
  wire day_end  = h12 ? (hr_q[4:0] == 5'h11 && hr_q[5]) : (hr_q[5:0] == 6'h23);

  wire leap = (!yr_q[4] && (yr_q[3:0] == 4'h0 || yr_q[3:0] == 4'h4 || yr_q[3:0] == 4'h8))
            || (yr_q[4] && (yr_q[3:0] == 4'h2 || yr_q[3:0] == 4'h6));
  wire short_mon = (mon_q == 8'h04) || (mon_q == 8'h06) || (mon_q == 8'h09) || (mon_q == 8'h11);
  wire [7:0] mdays = (mon_q == 8'h02) ? (leap ? 8'h29 : 8'h28) : (short_mon ? 8'h30 : 8'h31);

  wire c_sec = step & sec_wrap;
  wire c_min = c_sec & min_wrap;
  wire c_day = c_min & day_end;
  wire c_dat = c_day & (dat_q == mdays);
  wire c_mon = c_dat & (mon_q == 8'h12);
  wire c_yr  = c_mon;

  wire [7:0] t12 = bcd_step({3'b000, hr_q[4:0]});
  wire [7:0] t24 = bcd_step({2'b00, hr_q[5:0]});
  logic [7:0] hr_n;

  always_comb begin
    if (h12) begin
      if (hr_q[4:0] == 5'h12)      hr_n = {hr_q[7:5], 5'h01};
      else if (hr_q[4:0] == 5'h11) hr_n = {hr_q[7:6], ~hr_q[5], 5'h12};
      else                         hr_n = {hr_q[7:5], 5'h00} | t12;
    end else begin
      hr_n = (hr_q[5:0] == 6'h23) ? 8'h00 : t24;
    end
  end

  wire [7:0] sec_n = sec_wrap ? 8'h00 : bcd_step(sec_q);
  wire [7:0] min_n = min_wrap ? 8'h00 : bcd_step(min_q);
  wire [7:0] dow_n = (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
  wire [7:0] dat_n = (dat_q == mdays) ? 8'h01 : bcd_step(dat_q);
  wire [7:0] mon_n = (mon_q == 8'h12) ? 8'h01 : bcd_step(mon_q);
  wire [7:0] yr_n  = (yr_q == 8'h99) ? 8'h00 : bcd_step(yr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; dow_q <= '0;
      dat_q <= '0; mon_q <= '0; yr_q <= '0;
    end else begin
      if (wr_en && hit_wr(addr, 0)) sec_q <= wr_data & M_SEC;
      else if (step)                sec_q <= sec_n;
      if (wr_en && hit_wr(addr, 1)) min_q <= wr_data & M_MIN;
      else if (c_sec)               min_q <= min_n;
      if (wr_en && hit_wr(addr, 2)) hr_q <= wr_data & M_HR;
      else if (c_min)               hr_q <= hr_n;
      if (wr_en && hit_wr(addr, 3)) dow_q <= wr_data & M_DOW;
      else if (c_day)               dow_q <= dow_n;
      if (wr_en && hit_wr(addr, 4)) dat_q <= wr_data & M_DAT;
      else if (c_day)               dat_q <= dat_n;
      if (wr_en && hit_wr(addr, 5)) mon_q <= wr_data & M_MON;
      else if (c_dat)               mon_q <= mon_n;
      if (wr_en && hit_wr(addr, 6)) yr_q <= wr_data;
      else if (c_yr)                yr_q <= yr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sec <= '0; a_min <= '0; a_hr <= '0; a_day <= '0;
    end else if (wr_en) begin
      if (hit_wr(addr, 8))  a_sec <= wr_data;
      if (hit_wr(addr, 9))  a_min <= wr_data;
      if (hit_wr(addr, 10)) a_hr  <= wr_data;
      if (hit_wr(addr, 11)) a_day <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) snap[i] <= '0;
    end else if (rd_cmd) begin
      snap[0] <= sec_q; snap[1] <= min_q; snap[2] <= hr_q; snap[3] <= dow_q;
      snap[4] <= dat_q; snap[5] <= mon_q; snap[6] <= yr_q;
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rd_data = snap[0];
      AW'(1):  rd_data = snap[1];
      AW'(2):  rd_data = snap[2];
      AW'(3):  rd_data = snap[3];
      AW'(4):  rd_data = snap[4];
      AW'(5):  rd_data = snap[5];
      AW'(6):  rd_data = snap[6];
      AW'(8):  rd_data = a_sec;
      AW'(9):  rd_data = a_min;
      AW'(10): rd_data = a_hr;
      AW'(11): rd_data = a_day;
      default: rd_data = 8'h00;
    endcase
  end

  wire m_s = a_sec[6:0] == sec_q[6:0];
  wire m_m = a_min[6:0] == min_q[6:0];
  wire m_h = a_hr[6:0]  == hr_q[6:0];
  wire m_d = a_day[6] ? (a_day[5:0] == dow_q[5:0]) : (a_day[5:0] == dat_q[5:0]);
  wire hit = a_sec[7]
           | (a_min[7] & m_s)
           | (a_hr[7]  & m_s & m_m)
           | (a_day[7] & m_s & m_m & m_h)
           | (m_s & m_m & m_h & m_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_d     <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      tick_d     <= step;
      alarm_flag <= tick_d & run_en & alarm_en & hit;
    end
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       run_en,
  input logic       alarm_en,
  input logic       wr_en,
  input logic       rd_cmd,
  input logic       alarm_flag,
  input logic [7:0] sec_q,
  input logic [7:0] snap0
);
  assert_flag_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag |-> $past(alarm_en) && $past(run_en));

  assert_flag_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag |-> $past(tick_1hz, 2) && $past(run_en, 2));

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(tick_1hz && run_en) && !wr_en) |-> $stable(sec_q));

  assert_sec_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick_1hz && run_en && !wr_en) |-> sec_q[3:0] <= 4'd9);

  assert_snapshot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_cmd) |-> $stable(snap0));
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .run_en(run_en),
  .alarm_en(alarm_en), .wr_en(wr_en), .rd_cmd(rd_cmd), .alarm_flag(alarm_flag),
  .sec_q(sec_q), .snap0(snap[0])
);

// File: tb/tb_bcd_rtc.sv
`timescale 1ns/1ps
module tb_bcd_rtc;
  logic clk = 0, rst_n = 0;
  logic tick_1hz = 0, run_en = 0, alarm_en = 0, wr_en = 0, rd_cmd = 0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic alarm_flag;

  int checks = 0, fails = 0;
  bit done = 0;
  logic chk_req = 0;
  logic [7:0] exp_q[$];
  bit         isf_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  bcd_rtc dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .run_en(run_en),
    .alarm_en(alarm_en), .wr_en(wr_en), .rd_cmd(rd_cmd), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .alarm_flag(alarm_flag));

  always @(negedge clk) begin
    if (chk_req && exp_q.size() > 0) begin
      logic [7:0] e, o;
      bit f;
      string t;
      e = exp_q.pop_front(); f = isf_q.pop_front(); t = tag_q.pop_front();
      o = f ? {7'b0, alarm_flag} : rd_data;
      checks++;
      if (o !== e) begin
        fails++;
        $display("FAIL %s: got %02h expected %02h", t, o, e);
      end
    end
  end

  task automatic push(input bit f, input logic [7:0] e, input string t);
    exp_q.push_back(e); isf_q.push_back(f); tag_q.push_back(t);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t, input bit cap);
    if (cap) begin
      @(posedge clk); #1; rd_cmd = 1;
      @(posedge clk); #1; rd_cmd = 0;
    end else begin
      @(posedge clk); #1;
    end
    addr = a; push(0, e, t); chk_req = 1;
    @(posedge clk); #1; chk_req = 0;
  endtask

  task automatic tick(input bit ef, input string t);
    @(posedge clk); #1; tick_1hz = 1;
    @(posedge clk); #1; tick_1hz = 0;
    @(posedge clk); #1; push(1, {7'b0, ef}, t); chk_req = 1;
    @(posedge clk); #1; chk_req = 0;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 12; a++) if (a != 7) rd(4'(a), 8'h00, "R1 reset byte", 1);
    push(1, 8'h00, "R1 flag low"); chk_req = 1; @(posedge clk); #1 chk_req = 0;

    // R7 always-zero bits masked on write
    wr(4'd0, 8'hFF); rd(4'd0, 8'h7F, "R7 seconds mask", 1);
    wr(4'd3, 8'hFF); rd(4'd3, 8'h07, "R7 dow mask", 1);
    wr(4'd4, 8'hFF); rd(4'd4, 8'h3F, "R7 date mask", 1);
    wr(4'd5, 8'hFF); rd(4'd5, 8'h1F, "R7 month mask", 1);
    wr(4'd2, 8'hFF); rd(4'd2, 8'h7F, "R7 hour mask", 1);

    // R2 no counting with run_en low
    wr(4'd0, 8'h58); tick(0, "R2 flag idle"); rd(4'd0, 8'h58, "R2 halted", 1);

    // R2 R3 R5 R6 full rollover
    run_en = 1;
    set_hms(8'h23, 8'h59, 8'h59);
    wr(4'd3, 8'h07); wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99);
    tick(0, "R2 flag idle");
    rd(4'd0, 8'h00, "R2 sec wrap", 1); rd(4'd1, 8'h00, "R2 min wrap", 1);
    rd(4'd2, 8'h00, "R3 hour wrap", 1); rd(4'd3, 8'h01, "R5 dow wrap", 1);
    rd(4'd4, 8'h01, "R6 date wrap", 1); rd(4'd5, 8'h01, "R6 month wrap", 1);
    rd(4'd6, 8'h00, "R6 year wrap", 1);
    set_hms(8'h09, 8'h59, 8'h59); tick(0, "R3 flag idle");
    rd(4'd2, 8'h10, "R3 tens digit", 1);

    // R6 leap handling
    wr(4'd6, 8'h24); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59); tick(0, "R6 flag idle");
    rd(4'd4, 8'h29, "R6 leap 29th", 1);
    set_hms(8'h23, 8'h59, 8'h59); tick(0, "R6 flag idle");
    rd(4'd4, 8'h01, "R6 leap end", 1); rd(4'd5, 8'h03, "R6 to march", 1);
    wr(4'd6, 8'h23); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59); tick(0, "R6 flag idle");
    rd(4'd4, 8'h01, "R6 common feb", 1); rd(4'd5, 8'h03, "R6 common march", 1);
    wr(4'd6, 8'h00); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59); tick(0, "R6 flag idle");
    rd(4'd4, 8'h29, "R6 year 00 leap", 1);
    wr(4'd5, 8'h04); wr(4'd4, 8'h30);
    set_hms(8'h23, 8'h59, 8'h59); tick(0, "R6 flag idle");
    rd(4'd4, 8'h01, "R6 30 day", 1); rd(4'd5, 8'h05, "R6 30 day month", 1);

    // R4 12-hour mode
    wr(4'd3, 8'h03); wr(4'd4, 8'h05); wr(4'd5, 8'h01);
    set_hms(8'h51, 8'h59, 8'h59); tick(0, "R4 flag idle");
    rd(4'd2, 8'h72, "R4 11AM to 12PM", 1); rd(4'd3, 8'h03, "R4 no day change at noon", 1);
    set_hms(8'h72, 8'h59, 8'h59); tick(0, "R4 flag idle");
    rd(4'd2, 8'h61, "R4 12PM to 1PM", 1);
    set_hms(8'h71, 8'h59, 8'h59); tick(0, "R4 flag idle");
    rd(4'd2, 8'h52, "R4 11PM to 12AM", 1);
    rd(4'd3, 8'h04, "R4 midnight dow", 1); rd(4'd4, 8'h06, "R4 midnight date", 1);
    set_hms(8'h52, 8'h59, 8'h59); tick(0, "R4 flag idle");
    rd(4'd2, 8'h41, "R4 12AM to 1AM", 1);

    // R8 snapshot
    wr(4'd2, 8'h07); wr(4'd0, 8'h10); rd(4'd0, 8'h10, "R8 capture", 1);
    tick(0, "R8 flag idle");
    rd(4'd0, 8'h10, "R8 snapshot held", 0);
    rd(4'd0, 8'h11, "R8 recapture", 1);
    wr(4'd8, 8'h85); rd(4'd8, 8'h85, "R8 alarm live", 0);

    // R9 repeat rates
    alarm_en = 1;
    wr(4'd8, 8'h80); tick(1, "R9 every second"); tick(1, "R9 every second 2");
    wr(4'd8, 8'h30); wr(4'd9, 8'h80); wr(4'd0, 8'h28);
    tick(0, "R9 minute early"); tick(1, "R9 minute hit"); tick(0, "R9 minute after");
    wr(4'd8, 8'h00); wr(4'd9, 8'h15); wr(4'd10, 8'h80);
    wr(4'd1, 8'h14); wr(4'd0, 8'h59); tick(1, "R9 hourly hit");
    wr(4'd1, 8'h13); wr(4'd0, 8'h59); tick(0, "R9 hourly miss");
    wr(4'd9, 8'h00); wr(4'd10, 8'h08); wr(4'd11, 8'h80);
    set_hms(8'h07, 8'h59, 8'h59); tick(1, "R9 daily hit");
    set_hms(8'h06, 8'h59, 8'h59); tick(0, "R9 daily miss");

    // R10 day/date select
    wr(4'd11, 8'h43); wr(4'd3, 8'h03);
    set_hms(8'h07, 8'h59, 8'h59); tick(1, "R10 weekly hit");
    wr(4'd3, 8'h02); set_hms(8'h07, 8'h59, 8'h59); tick(0, "R10 weekly miss");
    wr(4'd11, 8'h03); wr(4'd3, 8'h03); wr(4'd4, 8'h04);
    set_hms(8'h07, 8'h59, 8'h59); tick(0, "R10 date selected not dow");
    wr(4'd4, 8'h03); set_hms(8'h07, 8'h59, 8'h59); tick(1, "R10 monthly hit");

    // R11 enables
    wr(4'd8, 8'h80);
    alarm_en = 0; tick(0, "R11 alarm_en low");
    alarm_en = 1; run_en = 0; tick(0, "R11 run_en low");
    run_en = 1; tick(1, "R11 both high");

    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule